// File: doc/BRIEF.md
# Capture/Compare Channel Bank

This block sits next to a free-running or task-driven counter. It gives that counter a set of channels. Each channel holds a 32-bit value. The value can be written by software or loaded from the counter by a one-cycle capture pulse. Each channel also watches the counter. When an increment lands exactly on the channel's value, the channel raises a sticky event flag.

Events can be routed back to the counter as one-cycle clear or stop requests, under control of a per-channel routing register. They also feed a single interrupt line through per-channel enables. Software sets those enables through one register address and removes them through another. A small word-addressed write/read port reaches every register. The comparison honours the counter's active width: bits above that width are ignored on both sides.

Top module: `cc_bank`

## Requirements
- R1: A one-cycle pulse on `cap_pulse[n]` loads the present `cnt_val` into the value register of channel n. The new value reads back from the next cycle on.
- R2: The event flag of channel n becomes set in the cycle after a cycle in which `cnt_inc` is high and `cnt_val` equals the channel's value. Equality that arises while `cnt_inc` is low, for example through a register write, sets no flag.
- R3: `width_sel` selects how many low bits take part in the comparison: 0 means 8 bits, 1 means 16, 2 means 24 and 3 means 32. Higher bits of both the counter and the value are ignored.
- R4: In the routing register (address 16), bit n enables channel n's event to clear the counter and bit 8+n enables it to stop the counter. `clr_req` and `stop_req` are one-cycle pulses in the cycle after the match. Several routed matches in one cycle give one pulse.
- R5: Event flags stay set until software writes a word with bit 0 equal to 0 to address 8+n. A write with bit 0 equal to 1 leaves the flag unchanged. A match in the same cycle as the clearing write leaves the flag set.
- R6: Interrupt enables sit at bit 16+n. A write to address 17 sets every enable whose data bit is 1, and a write to address 18 clears every enable whose data bit is 1. Zero bits have no effect on either address, and both addresses read back the current enables.
- R7: `irq` is high exactly when some channel has both its event flag and its interrupt enable set.
- R8: When a capture pulse and a software write hit the same channel in one cycle, the captured counter value is stored.
- R9: After reset, all value registers, event flags, routing bits and enables are 0, and `clr_req`, `stop_req` and `irq` are low.
- R10: Register map: value register n is at address n and event flag n at address 8+n, read as bit 0. Addresses with no register, including channel slots above the configured count, read 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cnt_val | input | 32 | Current counter value |
| cnt_inc | input | 1 | High in a cycle where `cnt_val` holds a freshly incremented value |
| width_sel | input | 2 | Active counter width code |
| cap_pulse | input | NUM_CH | Per-channel capture pulses |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 5 | Word address for write and read |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for `reg_addr` (combinational) |
| evt_flags | output | NUM_CH | Sticky event flags |
| clr_req | output | 1 | One-cycle clear request to the counter |
| stop_req | output | 1 | One-cycle stop request to the counter |
| irq | output | 1 | Combined interrupt |

## Verification
The hardest cases to reach are the collisions: a match in the same cycle as the write that clears its flag, and a capture in the same cycle as a write to that channel. The bench drives both inputs together in one cycle, then reads back the flag and the value. Width masking is tested with counter values whose low bits match but whose high bits differ. Each width code then decides the outcome. The channel values are chosen so that no other channel matches by accident.

// File: rtl/cc_pkg.sv
// Shared definitions for the capture/compare channel bank: the register
// map, the width codes and the comparison mask derived from them.
// Assumes a 32-bit counter and at most 8 channels (flag address range).
package cc_pkg;

    localparam int DATA_W      = 32;
    localparam int ADDR_W      = 5;
    localparam int FLAG_BASE   = 8;
    localparam int ADDR_ROUTE  = 16;
    localparam int ADDR_IEN_ON = 17;
    localparam int ADDR_IEN_OFF= 18;
    localparam int STOP_OFS    = 8;
    localparam int IEN_OFS     = 16;

    typedef enum logic [1:0] {
        WID_8  = 2'd0,
        WID_16 = 2'd1,
        WID_24 = 2'd2,
        WID_32 = 2'd3
    } width_e;

    // Bits of the counter that take part in a compare for a width code.
    function automatic logic [DATA_W-1:0] width_mask(width_e w);
        case (w)
            WID_8:   return 32'h0000_00FF;
            WID_16:  return 32'h0000_FFFF;
            WID_24:  return 32'h00FF_FFFF;
            default: return 32'hFFFF_FFFF;
        endcase
    endfunction

endpackage

// File: rtl/cc_channel.sv
// One capture/compare channel: a value register loaded by software or by
// a capture pulse (capture wins), a masked equality test qualified by the
// counter increment strobe, and a sticky event flag.
// Assumes cnt_val already holds the new value while cnt_inc is high.
module cc_channel
    import cc_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DATA_W-1:0] cnt_val,
    input  logic              cnt_inc,
    input  logic [DATA_W-1:0] cmp_mask,
    input  logic              cap,
    input  logic              wr_val,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              flag_clr,
    output logic [DATA_W-1:0] val,
    output logic              match,
    output logic              flag
);

    logic [DATA_W-1:0] val_q;
    logic              flag_q;

    // Value register: capture has priority over a software write.
    always_ff @(posedge clk) begin
        if (!rst_n)      val_q <= '0;
        else if (cap)    val_q <= cnt_val;
        else if (wr_val) val_q <= wr_data;
    end

    // Match only on an increment that lands on the masked value.
    always_comb match = cnt_inc && (((cnt_val ^ val_q) & cmp_mask) == '0);

    // Sticky flag: a match outranks a clearing write.
    always_ff @(posedge clk) begin
        if (!rst_n)        flag_q <= 1'b0;
        else if (match)    flag_q <= 1'b1;
        else if (flag_clr) flag_q <= 1'b0;
    end

    assign val  = val_q;
    assign flag = flag_q;

    AST_CAPTURE_LOADS: assert property (@(posedge clk) disable iff (!rst_n)
        cap |=> (val == $past(cnt_val)));                    // R1
    AST_FLAG_NEEDS_INC: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(flag) |-> $past(cnt_inc));                     // R2
    AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (flag && !flag_clr) |=> flag);                       // R5

endmodule

// File: rtl/cc_ctrl.sv
// Routing and interrupt control for the channel bank: routing bits that
// turn channel matches into one-cycle clear/stop pulses, set/clear style
// interrupt enables, and the combined interrupt.
// Assumes at most one of the three write strobes is high per cycle.
module cc_ctrl
    import cc_pkg::*;
#(
    parameter int NUM_CH = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NUM_CH-1:0] match,
    input  logic [NUM_CH-1:0] flags,
    input  logic              route_we,
    input  logic [NUM_CH-1:0] route_clr_data,
    input  logic [NUM_CH-1:0] route_stop_data,
    input  logic              ien_on_we,
    input  logic              ien_off_we,
    input  logic [NUM_CH-1:0] ien_data,
    output logic [DATA_W-1:0] route_img,
    output logic [DATA_W-1:0] ien_img,
    output logic              clr_req,
    output logic              stop_req,
    output logic              irq
);

    logic [NUM_CH-1:0] route_clr_q;
    logic [NUM_CH-1:0] route_stop_q;
    logic [NUM_CH-1:0] ien_q;
    logic              clr_q;
    logic              stop_q;

    // Routing register, written as a whole.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            route_clr_q  <= '0;
            route_stop_q <= '0;
        end else if (route_we) begin
            route_clr_q  <= route_clr_data;
            route_stop_q <= route_stop_data;
        end
    end

    // Interrupt enables: ones set through one address, clear through the other.
    always_ff @(posedge clk) begin
        if (!rst_n)          ien_q <= '0;
        else if (ien_on_we)  ien_q <= ien_q | ien_data;
        else if (ien_off_we) ien_q <= ien_q & ~ien_data;
    end

    // Clear/stop requests issued one cycle after a routed match.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            clr_q  <= 1'b0;
            stop_q <= 1'b0;
        end else begin
            clr_q  <= |(match & route_clr_q);
            stop_q <= |(match & route_stop_q);
        end
    end

    // Read images placing each field at its register bit position.
    always_comb begin
        route_img = '0;
        ien_img   = '0;
        route_img[NUM_CH-1:0]           = route_clr_q;
        route_img[STOP_OFS +: NUM_CH]   = route_stop_q;
        ien_img[IEN_OFS +: NUM_CH]      = ien_q;
    end

    assign clr_req  = clr_q;
    assign stop_req = stop_q;
    assign irq      = |(flags & ien_q);

    AST_STOP_NEEDS_ROUTE: assert property (@(posedge clk) disable iff (!rst_n)
        stop_req |-> ($past(route_stop_q) != '0));            // R4
    AST_IEN_SET_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
        ien_on_we |=> ((ien_q & $past(ien_data)) == $past(ien_data))); // R6
    AST_IRQ_HAS_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (flags != '0));                               // R7

endmodule

// File: rtl/cc_bank.sv
// Capture/compare channel bank: address decode of the register port, one
// cc_channel per channel, the routing/interrupt controller and the read
// multiplexer. Assumes 1 <= NUM_CH <= 8; reads are combinational.
module cc_bank
    import cc_pkg::*;
#(
    parameter int NUM_CH = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [31:0]       cnt_val,
    input  logic              cnt_inc,
    input  logic [1:0]        width_sel,
    input  logic [NUM_CH-1:0] cap_pulse,
    input  logic              reg_we,
    input  logic [4:0]        reg_addr,
    input  logic [31:0]       reg_wdata,
    output logic [31:0]       reg_rdata,
    output logic [NUM_CH-1:0] evt_flags,
    output logic              clr_req,
    output logic              stop_req,
    output logic              irq
);

    logic [DATA_W-1:0] cmp_mask;
    logic [DATA_W-1:0] ch_val [NUM_CH];
    logic [NUM_CH-1:0] ch_match;
    logic [NUM_CH-1:0] ch_flag;
    logic [DATA_W-1:0] route_img;
    logic [DATA_W-1:0] ien_img;

    // Comparison mask from the active width code.
    always_comb cmp_mask = width_mask(width_e'(width_sel));

    for (genvar n = 0; n < NUM_CH; n++) begin : g_ch
        logic wr_hit;
        logic clr_hit;
        // Per-channel write and flag-clear decode.
        always_comb begin
            wr_hit  = reg_we && (reg_addr == ADDR_W'(n));
            clr_hit = reg_we && (reg_addr == ADDR_W'(FLAG_BASE + n)) && !reg_wdata[0];
        end

        cc_channel i_channel (
            .clk      (clk),
            .rst_n    (rst_n),
            .cnt_val  (cnt_val),
            .cnt_inc  (cnt_inc),
            .cmp_mask (cmp_mask),
            .cap      (cap_pulse[n]),
            .wr_val   (wr_hit),
            .wr_data  (reg_wdata),
            .flag_clr (clr_hit),
            .val      (ch_val[n]),
            .match    (ch_match[n]),
            .flag     (ch_flag[n])
        );
    end

    cc_ctrl #(.NUM_CH(NUM_CH)) i_ctrl (
        .clk             (clk),
        .rst_n           (rst_n),
        .match           (ch_match),
        .flags           (ch_flag),
        .route_we        (reg_we && (reg_addr == ADDR_W'(ADDR_ROUTE))),
        .route_clr_data  (reg_wdata[NUM_CH-1:0]),
        .route_stop_data (reg_wdata[STOP_OFS +: NUM_CH]),
        .ien_on_we       (reg_we && (reg_addr == ADDR_W'(ADDR_IEN_ON))),
        .ien_off_we      (reg_we && (reg_addr == ADDR_W'(ADDR_IEN_OFF))),
        .ien_data        (reg_wdata[IEN_OFS +: NUM_CH]),
        .route_img       (route_img),
        .ien_img         (ien_img),
        .clr_req         (clr_req),
        .stop_req        (stop_req),
        .irq             (irq)
    );

    // Read multiplexer; unmapped addresses return zero.
    always_comb begin
        reg_rdata = '0;
        for (int i = 0; i < NUM_CH; i++) begin
            if (reg_addr == ADDR_W'(i))             reg_rdata = ch_val[i];
            if (reg_addr == ADDR_W'(FLAG_BASE + i)) reg_rdata = {31'b0, ch_flag[i]};
        end
        if (reg_addr == ADDR_W'(ADDR_ROUTE))   reg_rdata = route_img;
        if (reg_addr == ADDR_W'(ADDR_IEN_ON))  reg_rdata = ien_img;
        if (reg_addr == ADDR_W'(ADDR_IEN_OFF)) reg_rdata = ien_img;
    end

    assign evt_flags = ch_flag;

endmodule

// File: tb/test_cc_bank.sv
module test_cc_bank;

    localparam int NCH = 6;

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic [31:0]    cnt_val = '0;
    logic           cnt_inc = 1'b0;
    logic [1:0]     width_sel = 2'd3;
    logic [NCH-1:0] cap_pulse = '0;
    logic           reg_we = 1'b0;
    logic [4:0]     reg_addr = '0;
    logic [31:0]    reg_wdata = '0;
    logic [31:0]    reg_rdata;
    logic [NCH-1:0] evt_flags;
    logic           clr_req;
    logic           stop_req;
    logic           irq;

    cc_bank #(.NUM_CH(NCH)) i_cc_bank (
        .clk(clk), .rst_n(rst_n), .cnt_val(cnt_val), .cnt_inc(cnt_inc),
        .width_sel(width_sel), .cap_pulse(cap_pulse), .reg_we(reg_we),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .evt_flags(evt_flags), .clr_req(clr_req), .stop_req(stop_req), .irq(irq)
    );

    always #4 clk = ~clk;

    typedef struct {
        int          cyc;
        int          kind;   // 0 rdata, 1 flags, 2 clr, 3 stop, 4 irq
        logic [31:0] exp;
        string       req;
    } item_t;

    item_t       sbq[$];
    int          cyc = 0;
    int          n_vec = 0;
    int          n_bad = 0;
    bit          done = 1'b0;
    item_t       mon_it;
    logic [31:0] mon_act;

    always @(posedge clk) cyc <= cyc + 1;

    // Monitor: pops expectations due this cycle and compares mid-cycle.
    always @(negedge clk) begin
        while (sbq.size() > 0 && sbq[0].cyc <= cyc) begin
            mon_it = sbq.pop_front();
            case (mon_it.kind)
                0:       mon_act = reg_rdata;
                1:       mon_act = 32'(evt_flags);
                2:       mon_act = 32'(clr_req);
                3:       mon_act = 32'(stop_req);
                default: mon_act = 32'(irq);
            endcase
            n_vec++;
            if (mon_act !== mon_it.exp) begin
                n_bad++;
                $display("FAIL %s kind=%0d actual=%h expected=%h",
                         mon_it.req, mon_it.kind, mon_act, mon_it.exp);
            end
        end
    end

    task automatic step();
        @(posedge clk); #1;
    endtask

    task automatic expect_out(int kind, logic [31:0] exp, string req);
        item_t it;
        it.cyc = cyc; it.kind = kind; it.exp = exp; it.req = req;
        sbq.push_back(it);
    endtask

    task automatic expect_rd(logic [4:0] a, logic [31:0] exp, string req);
        reg_addr = a;
        expect_out(0, exp, req);
        step();
    endtask

    task automatic wr(logic [4:0] a, logic [31:0] d);
        reg_addr = a; reg_wdata = d; reg_we = 1'b1;
        step();
        reg_we = 1'b0;
    endtask

    task automatic bump(logic [31:0] v);
        cnt_val = v; cnt_inc = 1'b1;
        step();
        cnt_inc = 1'b0;
    endtask

    initial begin
        repeat (3) step();
        rst_n = 1'b1;
        step();
        // R9: reset state
        expect_out(1, 0, "R9"); expect_out(2, 0, "R9");
        expect_out(3, 0, "R9"); expect_out(4, 0, "R9");
        expect_rd(5'd0, 0, "R9");
        expect_rd(5'd16, 0, "R9");
        expect_rd(5'd17, 0, "R9");

        // R10: map and unmapped reads
        wr(5'd2, 32'hDEAD_BEEF);
        expect_rd(5'd2, 32'hDEAD_BEEF, "R10");
        expect_rd(5'd6, 0, "R10");
        expect_rd(5'd20, 0, "R10");

        // R1: capture
        cnt_val = 32'h0000_1234; cap_pulse = 6'b000010;
        step();
        cap_pulse = '0;
        expect_rd(5'd1, 32'h0000_1234, "R1");

        // R8: capture and write together
        cnt_val = 32'h0000_0055; cap_pulse = 6'b001000;
        reg_we = 1'b1; reg_addr = 5'd3; reg_wdata = 32'h0000_AAAA;
        step();
        reg_we = 1'b0; cap_pulse = '0;
        expect_rd(5'd3, 32'h0000_0055, "R8");

        // R2: equality by write does not fire; increment onto value does
        wr(5'd0, 32'd10);
        cnt_val = 32'h77;
        wr(5'd5, 32'h77);
        step();
        expect_out(1, 0, "R2");
        bump(32'd10);
        expect_out(1, 32'h1, "R2");
        expect_rd(5'd8, 32'h1, "R10");

        // R5: sticky, write of 1 ignored, write of 0 clears, match wins
        step(); step();
        expect_out(1, 32'h1, "R5");
        wr(5'd8, 32'h1);
        expect_out(1, 32'h1, "R5");
        wr(5'd8, 32'h0);
        expect_out(1, 32'h0, "R5");
        cnt_val = 32'd10; cnt_inc = 1'b1;
        reg_we = 1'b1; reg_addr = 5'd8; reg_wdata = 32'h0;
        step();
        cnt_inc = 1'b0; reg_we = 1'b0;
        expect_out(1, 32'h1, "R5");
        wr(5'd8, 32'h0);

        // R3: width masking
        width_sel = 2'd0;
        bump(32'h0000_FF0A);
        expect_out(1, 32'h1, "R3");
        wr(5'd8, 32'h0);
        width_sel = 2'd1;
        bump(32'h0000_FF0A);
        expect_out(1, 32'h0, "R3");
        width_sel = 2'd2;
        bump(32'hAB00_000A);
        expect_out(1, 32'h1, "R3");
        wr(5'd8, 32'h0);
        width_sel = 2'd3;
        bump(32'hAB00_000A);
        expect_out(1, 32'h0, "R3");

        // R4: routing to clear/stop pulses
        wr(5'd16, 32'h0000_0201);
        expect_rd(5'd16, 32'h0000_0201, "R4");
        bump(32'd10);
        expect_out(2, 1, "R4"); expect_out(3, 0, "R4");
        step();
        expect_out(2, 0, "R4");
        bump(32'h0000_1234);
        expect_out(3, 1, "R4"); expect_out(2, 0, "R4");
        step();
        expect_out(3, 0, "R4");
        bump(32'h0000_0055);
        expect_out(2, 0, "R4"); expect_out(3, 0, "R4");
        expect_out(1, 32'h0B, "R4");
        wr(5'd8, 0); wr(5'd9, 0); wr(5'd11, 0);

        // R6 / R7: interrupt enables and combined line
        wr(5'd17, 32'h0001_0000);
        expect_out(4, 0, "R7");
        expect_rd(5'd17, 32'h0001_0000, "R6");
        expect_rd(5'd18, 32'h0001_0000, "R6");
        bump(32'd10);
        expect_out(4, 1, "R7");
        wr(5'd17, 32'h0);
        expect_rd(5'd17, 32'h0001_0000, "R6");
        wr(5'd18, 32'h0);
        expect_rd(5'd18, 32'h0001_0000, "R6");
        wr(5'd18, 32'h0001_0000);
        expect_out(4, 0, "R7");
        expect_rd(5'd17, 32'h0, "R6");
        wr(5'd17, 32'h0002_0000);
        expect_out(4, 0, "R7");
        bump(32'h0000_1234);
        expect_out(4, 1, "R7");
        expect_out(3, 1, "R4");

        step(); step();
        if (!done) begin
            done = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

    // Watchdog: a hung run counts as one failed check.
    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_bad++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

endmodule